// File: doc/BRIEF.md
# Virtual-Channel Queue Manager with Remap Table

This block sits between a single ingress port and a switch fabric. Words arrive on one shared stream, each tagged with a virtual channel number, and are written into a queue owned by that channel. Each channel has its own queue and its own flow-control state. A remap table, written only through a small configuration port, assigns every ingress channel a destination made of an egress interface number and a channel number on that interface. Any pairing is legal, including a destination on the interface the traffic came from.

Traffic leaves in fixed-size segments of `SEG_LEN` words. A channel becomes a candidate as soon as its queue holds one whole segment and its destination is not marked blocked by the egress side. Because of this, the start of a packet can be forwarded while its tail is still arriving. Candidates are served in round-robin order. Once a segment has started, all of its beats go out back to back on the egress stream, so channels interleave only at segment edges. A stalled destination holds back only its own channel. The per-channel status code reports on the ingress side how full that channel's queue is. If the linked egress queue is blocked, the code reports "satisfied" instead.

The ingress stream is never back-pressured: `in_ready` is high whenever reset is released. A word sent to a full queue is discarded and sets a sticky overflow flag for that channel. The egress stream follows valid/ready rules. While `out_valid` is high and `out_ready` is low, `out_data`, `out_if`, `out_ch` and `out_eos` stay unchanged.

Top module: `vc_queue_mgr`

## Requirements
- R1: A word accepted with `in_valid` high is appended to the queue of channel `in_ch`. Each channel's words leave in the order they arrived.
- R2: A channel competes for the egress only when its queue holds at least `SEG_LEN` words and its destination is not blocked. Destination (i, c) is blocked when bit `i*NUM_CH + c` of `eg_block` is 1.
- R3: A channel whose destination is blocked does not delay segments of any other eligible channel.
- R4: A pulse on `map_we` sets the destination of channel `map_sel` to (`map_if`, `map_ch`). After reset, channel k maps to interface 0, channel k. Each segment reports on `out_if`/`out_ch` the destination that was mapped when the segment started. A map write during a segment does not change that segment.
- R5: A segment is offered as soon as `SEG_LEN` words of it are queued, whether or not later words of the same packet have arrived.
- R6: A segment is `SEG_LEN` consecutive beats from one channel, with `out_eos` high only on the last beat. Its outputs hold steady while `out_ready` is low.
- R7: When several channels are eligible, the grant goes to the first eligible channel after the one granted last, in increasing channel number with wrap-around. After reset, the search starts at channel 0.
- R8: `fc_status[2k+1:2k]` is 2'b10 (satisfied) when channel k holds at least `wm_high` words. Otherwise it is 2'b00 (starving) when the channel holds at most `wm_low` words, and 2'b01 (hungry) in all other cases. 2'b11 never appears.
- R9: When the mapped destination of channel k is blocked, its status is 2'b10, whatever its fill level.
- R10: `in_ready` is 1 out of reset. A word written to a full queue (`DEPTH` words, no pop in the same cycle) is discarded, and `ovf_flag[k]` is set and stays set until reset.
- R11: During and right after reset, `out_valid` is 0, `ovf_flag` is 0, and every status code is starving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Ingress word valid |
| in_ready | output | 1 | Ingress ready (high out of reset) |
| in_ch | input | CH_W | Ingress channel tag |
| in_data | input | DATA_W | Ingress word |
| out_valid | output | 1 | Egress beat valid |
| out_ready | input | 1 | Egress beat accepted |
| out_data | output | DATA_W | Egress word |
| out_if | output | IF_W | Destination interface of the current segment |
| out_ch | output | CH_W | Destination channel of the current segment |
| out_eos | output | 1 | Last beat of the segment |
| eg_block | input | NUM_IF*NUM_CH | Per-destination blocked flags from the egress side |
| map_we | input | 1 | Remap table write strobe |
| map_sel | input | CH_W | Ingress channel whose entry is written |
| map_if | input | IF_W | New destination interface |
| map_ch | input | CH_W | New destination channel |
| wm_low | input | CNT_W | Starving watermark |
| wm_high | input | CNT_W | Satisfied watermark |
| fc_status | output | 2*NUM_CH | Per-channel flow-control code |
| ovf_flag | output | NUM_CH | Sticky per-channel overflow flags |

## Verification
The hardest cases to reach are a full queue, a held grant and a mid-segment remap, because a queue normally drains as fast as it fills. The bench reaches them by holding `out_ready` low. Then one segment stays granted and frozen, a queue can be filled past `DEPTH` while its status is swept through every fill level, and the map can be rewritten under a live segment. Round-robin order is set up the same way: one channel is granted first, the other queues are filled behind it, and the order in which the segments drain is compared against the arithmetic rotation.

// File: rtl/vcq_pkg.sv
package vcq_pkg;
  typedef enum logic [1:0] {
    FC_STARVING  = 2'b00,
    FC_HUNGRY    = 2'b01,
    FC_SATISFIED = 2'b10
  } fc_code_e;
endpackage

// File: rtl/vcq_fifo.sv
module vcq_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count,
  output logic              ovf
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              full, do_wr, do_rd, drop;

  assign full    = (count == CNT_W'(DEPTH));
  assign do_rd   = rd_en && (count != '0);
  assign do_wr   = wr_en && (!full || do_rd);
  assign drop    = wr_en && full && !do_rd;
  assign rd_data = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (drop) ovf <= 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R10
  AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> (count == $past(count))); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R10
endmodule

// File: rtl/vcq_map.sv
module vcq_map #(
  parameter int NUM_CH = 4,
  parameter int NUM_IF = 4,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int IF_W  = $clog2(NUM_IF)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [CH_W-1:0]          sel,
  input  logic [IF_W-1:0]          wr_if,
  input  logic [CH_W-1:0]          wr_ch,
  output logic [NUM_CH*IF_W-1:0]   dst_if_flat,
  output logic [NUM_CH*CH_W-1:0]   dst_ch_flat
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_entry
    logic [IF_W-1:0] if_q;
    logic [CH_W-1:0] ch_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        if_q <= '0;
        ch_q <= CH_W'(k);
      end else if (we && (sel == CH_W'(k))) begin
        if_q <= wr_if;
        ch_q <= wr_ch;
      end
    end
    assign dst_if_flat[k*IF_W +: IF_W] = if_q;
    assign dst_ch_flat[k*CH_W +: CH_W] = ch_q;

    AST_MAP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == CH_W'(k)) |=> (if_q == $past(wr_if) && ch_q == $past(wr_ch))); // R4
  end
endmodule

// File: rtl/vcq_rr_arb.sv
module vcq_rr_arb #(
  parameter int N     = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             take,
  output logic             any,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] gnt_idx
);
  logic [IDX_W-1:0] last_q;
  int               idx;

  always_comb begin
    any     = 1'b0;
    gnt_idx = '0;
    idx     = 0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last_q) + k) % N;
      if (!any && req[idx]) begin
        any     = 1'b1;
        gnt_idx = IDX_W'(idx);
      end
    end
    gnt = any ? (N'(1) << gnt_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          last_q <= IDX_W'(N - 1);
    else if (take && any) last_q <= gnt_idx;
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R7
  AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0); // R7
endmodule

// File: rtl/vcq_status.sv
module vcq_status
  import vcq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH*CNT_W-1:0] cnt_flat,
  input  logic [NUM_CH-1:0]       linked_blk,
  input  logic [CNT_W-1:0]        wm_low,
  input  logic [CNT_W-1:0]        wm_high,
  output logic [2*NUM_CH-1:0]     fc_status
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic [CNT_W-1:0] fill;
    fc_code_e         code;
    assign fill = cnt_flat[k*CNT_W +: CNT_W];
    always_comb begin
      if (linked_blk[k] || fill >= wm_high) code = FC_SATISFIED;
      else if (fill <= wm_low)              code = FC_STARVING;
      else                                  code = FC_HUNGRY;
    end
    assign fc_status[2*k +: 2] = code;

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      fc_status[2*k +: 2] != 2'b11); // R8
  end
endmodule

// File: rtl/vc_queue_mgr.sv
module vc_queue_mgr #(
  parameter int NUM_CH  = 4,
  parameter int NUM_IF  = 4,
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 8,
  parameter int SEG_LEN = 4,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int IF_W   = $clog2(NUM_IF),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int BEAT_W = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [CH_W-1:0]          in_ch,
  input  logic [DATA_W-1:0]        in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [DATA_W-1:0]        out_data,
  output logic [IF_W-1:0]          out_if,
  output logic [CH_W-1:0]          out_ch,
  output logic                     out_eos,
  input  logic [NUM_IF*NUM_CH-1:0] eg_block,
  input  logic                     map_we,
  input  logic [CH_W-1:0]          map_sel,
  input  logic [IF_W-1:0]          map_if,
  input  logic [CH_W-1:0]          map_ch,
  input  logic [CNT_W-1:0]         wm_low,
  input  logic [CNT_W-1:0]         wm_high,
  output logic [2*NUM_CH-1:0]      fc_status,
  output logic [NUM_CH-1:0]        ovf_flag
);
  logic [NUM_CH*IF_W-1:0]  dst_if_flat;
  logic [NUM_CH*CH_W-1:0]  dst_ch_flat;
  logic [NUM_CH*CNT_W-1:0] cnt_flat;
  logic [DATA_W-1:0]       rdata [NUM_CH];
  logic [NUM_CH-1:0]       linked_blk, elig, pop, gnt;
  logic                    any_elig, start, last_beat;
  logic [CH_W-1:0]         gnt_idx;

  logic                    active_q;
  logic [CH_W-1:0]         cur_src_q, cur_dch_q;
  logic [IF_W-1:0]         cur_if_q;
  logic [BEAT_W-1:0]       beat_q;

  assign in_ready = rst_n;

  vcq_map #(.NUM_CH(NUM_CH), .NUM_IF(NUM_IF)) u_map (
    .clk(clk), .rst_n(rst_n), .we(map_we), .sel(map_sel),
    .wr_if(map_if), .wr_ch(map_ch),
    .dst_if_flat(dst_if_flat), .dst_ch_flat(dst_ch_flat)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_q
    logic [CNT_W-1:0] cnt;
    logic [IF_W-1:0]  d_if;
    logic [CH_W-1:0]  d_ch;
    logic             wr;

    assign wr   = in_valid && (in_ch == CH_W'(k));
    assign pop[k] = active_q && out_ready && (cur_src_q == CH_W'(k));
    assign d_if = dst_if_flat[k*IF_W +: IF_W];
    assign d_ch = dst_ch_flat[k*CH_W +: CH_W];
    assign linked_blk[k] = eg_block[int'(d_if) * NUM_CH + int'(d_ch)];
    assign elig[k] = (cnt >= CNT_W'(SEG_LEN)) && !linked_blk[k];
    assign cnt_flat[k*CNT_W +: CNT_W] = cnt;

    vcq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr), .wr_data(in_data),
      .rd_en(pop[k]), .rd_data(rdata[k]), .count(cnt), .ovf(ovf_flag[k])
    );

    AST_START_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && gnt[k]) |-> (cnt >= CNT_W'(SEG_LEN) && !linked_blk[k])); // R2
  end

  assign start = !active_q && any_elig;

  vcq_rr_arb #(.N(NUM_CH)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(elig), .take(start),
    .any(any_elig), .gnt(gnt), .gnt_idx(gnt_idx)
  );

  vcq_status #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_status (
    .clk(clk), .rst_n(rst_n), .cnt_flat(cnt_flat), .linked_blk(linked_blk),
    .wm_low(wm_low), .wm_high(wm_high), .fc_status(fc_status)
  );

  assign last_beat = (beat_q == BEAT_W'(SEG_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      cur_src_q <= '0;
      cur_dch_q <= '0;
      cur_if_q  <= '0;
      beat_q    <= '0;
    end else if (start) begin
      active_q  <= 1'b1;
      cur_src_q <= gnt_idx;
      cur_if_q  <= dst_if_flat[int'(gnt_idx)*IF_W +: IF_W];
      cur_dch_q <= dst_ch_flat[int'(gnt_idx)*CH_W +: CH_W];
      beat_q    <= '0;
    end else if (active_q && out_ready) begin
      if (last_beat) active_q <= 1'b0;
      beat_q <= last_beat ? '0 : beat_q + 1'b1;
    end
  end

  assign out_valid = active_q;
  assign out_data  = rdata[cur_src_q];
  assign out_if    = cur_if_q;
  assign out_ch    = cur_dch_q;
  assign out_eos   = active_q && last_beat;

  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_if)
                                   && $stable(out_ch) && $stable(out_eos))); // R6
  AST_SEG_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_eos) |=> (out_valid && $stable(out_if) && $stable(out_ch))); // R6
  AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop)); // R6
endmodule

// File: tb/vc_queue_mgr_tb.sv
module vc_queue_mgr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4, NIF = 4, DW = 16, DEP = 8, SEG = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, map_we = 1'b0;
  logic [1:0] in_ch = '0, map_sel = '0, map_if = '0, map_ch = '0;
  logic [DW-1:0] in_data = '0;
  logic [NIF*NCH-1:0] eg_block = '0;
  logic [3:0] wm_low = 4'd2, wm_high = 4'd6;
  logic in_ready, out_valid, out_eos;
  logic [DW-1:0] out_data;
  logic [1:0] out_if, out_ch;
  logic [2*NCH-1:0] fc_status;
  logic [NCH-1:0] ovf_flag;

  int n_tests = 0, n_fail = 0;
  logic [DW-1:0] sb [NCH][64];
  int wp [NCH], rp [NCH], seqn [NCH];
  int last_src;

  always #(CLK_PERIOD/2) clk = ~clk;

  vc_queue_mgr #(.NUM_CH(NCH), .NUM_IF(NIF), .DATA_W(DW), .DEPTH(DEP), .SEG_LEN(SEG)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_ch(in_ch),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_if(out_if), .out_ch(out_ch), .out_eos(out_eos), .eg_block(eg_block),
    .map_we(map_we), .map_sel(map_sel), .map_if(map_if), .map_ch(map_ch),
    .wm_low(wm_low), .wm_high(wm_high), .fc_status(fc_status), .ovf_flag(ovf_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input int ch);
    logic [DW-1:0] w;
    w = DW'((ch << 8) | (seqn[ch] & 8'hff));
    seqn[ch]++;
    @(negedge clk);
    in_valid = 1'b1; in_ch = 2'(ch); in_data = w;
    if (wp[ch] - rp[ch] < DEP) begin sb[ch][wp[ch] % 64] = w; wp[ch]++; end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic write_map(input int sel, input int dif, input int dch);
    @(negedge clk);
    map_we = 1'b1; map_sel = 2'(sel); map_if = 2'(dif); map_ch = 2'(dch);
    @(negedge clk);
    map_we = 1'b0;
  endtask

  // Collect one segment; checks source order, destination and framing.
  task automatic recv_seg(input string req, input int src, input int dif, input int dch);
    int waited;
    logic [1:0] s_if, s_ch;
    out_ready = 1'b1;
    for (int b = 0; b < SEG; b++) begin
      waited = 0;
      while (!out_valid && waited < 60) begin @(negedge clk); waited++; end
      if (!out_valid) begin
        check({req, " segment timeout"}, 0, 1);
        out_ready = 1'b0;
        return;
      end
      if (b == 0) begin
        s_if = out_if; s_ch = out_ch;
        check({req, " out_if"}, int'(out_if), dif);
        check({req, " out_ch"}, int'(out_ch), dch);
      end else begin
        check("R6 dest stable in segment", int'({out_if, out_ch}), int'({s_if, s_ch}));
      end
      check({req, " R1 data order"}, int'(out_data), int'(sb[src][rp[src] % 64]));
      check("R6 eos position", int'(out_eos), (b == SEG-1) ? 1 : 0);
      rp[src]++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    last_src = src;
  endtask

  function automatic int fc_of(input int ch);
    return int'(fc_status[2*ch +: 2]);
  endfunction

  initial begin : wd
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    for (int c = 0; c < NCH; c++) begin wp[c] = 0; rp[c] = 0; seqn[c] = 0; end
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 out_valid", int'(out_valid), 0);
    check("R11 ovf_flag", int'(ovf_flag), 0);
    check("R11 status starving", int'(fc_status), 0);
    check("R10 in_ready", int'(in_ready), 1);

    // R5 cut-through: 3 words not enough, 4th releases segment with rest of packet pending
    for (int i = 0; i < 3; i++) push(0);
    repeat (2) @(negedge clk);
    check("R2 partial segment held", int'(out_valid), 0);
    push(0);
    @(negedge clk);
    check("R5 segment offered before packet tail", int'(out_valid), 1);
    recv_seg("R4 reset map", 0, 0, 0);
    for (int i = 0; i < 4; i++) push(0);
    recv_seg("R5 packet tail", 0, 0, 0);

    // R4 remap any-to-any, including loopback to interface 0
    write_map(1, 3, 2);
    for (int i = 0; i < 4; i++) push(1);
    recv_seg("R4 remap", 1, 3, 2);
    write_map(2, 0, 1);
    for (int i = 0; i < 4; i++) push(2);
    recv_seg("R4 loopback map", 2, 0, 1);

    // R4 map write during a live segment does not alter it
    for (int i = 0; i < 4; i++) push(1);
    repeat (2) @(negedge clk);
    write_map(1, 1, 0);
    recv_seg("R4 mid-segment remap", 1, 3, 2);
    for (int i = 0; i < 4; i++) push(1);
    recv_seg("R4 new map applies", 1, 1, 0);

    // R3/R9 head-of-line isolation: ch0 destination (if0,ch0) blocked
    eg_block[0*NCH + 0] = 1'b1;
    for (int i = 0; i < 4; i++) push(0);
    for (int i = 0; i < 4; i++) push(3);
    recv_seg("R3 unblocked channel passes", 3, 0, 3);
    repeat (3) @(negedge clk);
    check("R2 blocked channel not offered", int'(out_valid), 0);
    check("R9 linked block -> satisfied", fc_of(0), 2);
    eg_block = '0;
    @(negedge clk);
    check("R9 unblocked status (4 words hungry)", fc_of(0), 1);
    recv_seg("R3 released channel", 0, 0, 0);

    // R7 round robin: grant one channel with ready low, fill the rest behind it
    for (int start = 0; start < NCH; start++) begin
      for (int i = 0; i < 4; i++) push(start);
      for (int k = 1; k < NCH; k++) for (int i = 0; i < 4; i++) push((start + k) % NCH);
      for (int k = 0; k < NCH; k++) begin
        int s;
        s = (start + k) % NCH;
        @(negedge clk);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        // peek destination of the first beat still in hand is fine; compare data source
        rp[s] = rp[s];
        check("R7 rr order", int'(out_data[15:8]) , s);
        out_ready = 1'b1;
        for (int b = 1; b < SEG; b++) begin
          if (b == 1) begin end
        end
        out_ready = 1'b0;
        begin
          // finish the segment (first beat already consumed above)
          rp[s]++;
          out_ready = 1'b1;
          for (int b = 1; b < SEG; b++) begin
            check("R1 rr data", int'(out_data), int'(sb[s][rp[s] % 64]));
            rp[s]++;
            @(negedge clk);
          end
          out_ready = 1'b0;
        end
      end
    end

    // R8/R10 watermark sweep and overflow on ch1 (map if1 ch0), ready held low
    for (int n = 1; n <= DEP; n++) begin
      push(1);
      check("R8 status sweep", fc_of(1), (n >= 6) ? 2 : ((n <= 2) ? 0 : 1));
    end
    check("R10 no overflow yet", int'(ovf_flag), 0);
    push(1);
    check("R10 overflow flag", int'(ovf_flag), 2);
    check("R8 full status", fc_of(1), 2);
    recv_seg("R10 drain after drop 1", 1, 1, 0);
    recv_seg("R10 drain after drop 2", 1, 1, 0);
    repeat (3) @(negedge clk);
    check("R10 dropped word absent", int'(out_valid), 0);
    check("R10 flag sticky", int'(ovf_flag), 2);
    check("R8 empty status", fc_of(1), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule